// File: doc/BRIEF.md
# CAN Bit Stuffing Codec

This block enforces the CAN stuffing rule on both directions of a node's serial bit stream. It advances by one bit per sample-point strobe (`bit_stb`). On the transmit side, the frame controller offers payload bits through a ready/valid handshake. After a run of equal bus levels, the codec inserts a complementary stuff bit on `tx_bit` and stalls the payload for that strobe. On the receive side, the sampled bus bit arrives on `rx_bit`. The codec removes stuff bits from the data stream and raises a one-strobe error pulse when a run grows one bit too long.

The frame controller marks the start-of-frame bit on each side with `tx_sof` / `rx_sof`, which restarts run counting. It drops `stuff_en` for the fixed-form tail of a frame, where long runs are legal. A stuff violation halts reception until the next start-of-frame mark. Reacting to the error is left to the surrounding frame logic.

Top module: `can_stuff_codec`

## Requirements
- R1: With `stuff_en` high, when RUN_LEN (default 5) consecutive transmitted bits have the same level, the next strobe drives a stuff bit of the opposite level on `tx_bit` before any further payload bit, and asserts `tx_is_stuff` with it. The stuff bit counts as the first bit of a new run. Level 0 is dominant and level 1 is recessive.
- R2: `tx_ready` is low from the strobe that launches the RUN_LEN-th equal bit until the strobe that launches the stuff bit. A payload bit offered during that time is not consumed.
- R3: A bit marked with `tx_sof` or `rx_sof` starts a run of length one, whatever bits came before it.
- R4: At a receive strobe, the bit that follows RUN_LEN equal bits is discarded when its level is opposite (`rx_data_valid` low). Every other bit is delivered with `rx_data_valid` high and `rx_data` equal to `rx_bit`.
- R5: A received bit that has the same level as the RUN_LEN bits before it raises `rx_stuff_err` for that strobe only, and that bit is not delivered.
- R6: After a stuff error, `rx_data_valid` stays low until a strobe with `rx_sof` high.
- R7: With `stuff_en` low, no stuff bit is inserted, `tx_ready` stays high, no stuff error is raised, and every received bit is delivered.
- R8: State and `tx_bit` change only at strobes. `rx_data_valid` and `rx_stuff_err` are low when `bit_stb` is low.
- R9: After reset, and at any strobe with no payload offered and no stuff bit due, `tx_bit` is recessive (1). A later payload bit then starts a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb | input | 1 | Sample-point strobe, one per bit time |
| stuff_en | input | 1 | Stuffing enable for both directions |
| tx_valid | input | 1 | Payload bit offered |
| tx_data | input | 1 | Payload bit level |
| tx_sof | input | 1 | Offered bit is the start-of-frame bit |
| tx_ready | output | 1 | Payload bit will be consumed at the next strobe |
| tx_bit | output | 1 | Bus level driven for the current bit time |
| tx_is_stuff | output | 1 | Current `tx_bit` is a stuff bit |
| rx_bit | input | 1 | Sampled bus level |
| rx_sof | input | 1 | Sampled bit is the start-of-frame bit |
| rx_data_valid | output | 1 | Sampled bit is a data bit (strobe-aligned) |
| rx_data | output | 1 | Level of the delivered data bit |
| rx_stuff_err | output | 1 | Stuff violation pulse (strobe-aligned) |

## Verification
When `tx_bit` is looped back into `rx_bit`, the receiver discards the stuff bit at the strobe where the transmitter resumes, and consumes the next payload bit. At such a strobe, removal and the transmit handshake act in the same cycle. Every 10-bit payload behind a dominant start-of-frame bit is sent through this loop. The bench predicts the stuffed stream, the stall count and the recovered payload arithmetically. Any extra, missing or misplaced stuff bit on either side therefore shows up as a mismatch or a spurious error.

// File: rtl/can_stuff_pkg.sv
package can_stuff_pkg;
  localparam int unsigned DEF_RUN_LEN = 5;
  localparam logic LVL_DOM = 1'b0;
  localparam logic LVL_REC = 1'b1;
endpackage

// File: rtl/stuff_run_tracker.sv
module stuff_run_tracker #(
  parameter int unsigned RUN_LEN = can_stuff_pkg::DEF_RUN_LEN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic restart,
  input  logic clear,
  input  logic bit_in,
  output logic full,
  output logic lvl
);
  localparam int unsigned CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(RUN_LEN);
  localparam logic [CW-1:0] ONE_CNT  = CW'(1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;

  always_comb begin
    cnt_d = cnt_q;
    lvl_d = lvl_q;
    if (clear) begin
      cnt_d = '0;
    end else if (step) begin
      lvl_d = bit_in;
      if (restart || (cnt_q == '0) || (bit_in != lvl_q)) begin
        cnt_d = ONE_CNT;
      end else if (cnt_q != FULL_CNT) begin
        cnt_d = cnt_q + ONE_CNT;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lvl_q <= can_stuff_pkg::LVL_REC;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign full = (cnt_q == FULL_CNT);
  assign lvl  = lvl_q;

  // R1: run length never exceeds the stuffing limit
  p_run_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);
endmodule

// File: rtl/stuff_tx.sv
module stuff_tx #(
  parameter int unsigned RUN_LEN = can_stuff_pkg::DEF_RUN_LEN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic stuff_en,
  input  logic tx_valid,
  input  logic tx_data,
  input  logic tx_sof,
  output logic tx_ready,
  output logic tx_bit,
  output logic tx_is_stuff
);
  logic run_full, run_lvl;
  logic stuff_due;
  logic trk_step, trk_restart, trk_clear, trk_bit;
  logic bus_q, bus_d, stf_q, stf_d;

  assign stuff_due   = stuff_en && run_full;
  assign trk_step    = bit_stb && stuff_en && (stuff_due || tx_valid);
  assign trk_restart = !stuff_due && tx_sof;
  assign trk_clear   = bit_stb && (!stuff_en || (!stuff_due && !tx_valid));
  assign trk_bit     = stuff_due ? ~run_lvl : tx_data;

  stuff_run_tracker #(.RUN_LEN(RUN_LEN)) u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (trk_step),
    .restart (trk_restart),
    .clear   (trk_clear),
    .bit_in  (trk_bit),
    .full    (run_full),
    .lvl     (run_lvl)
  );

  always_comb begin
    bus_d = bus_q;
    stf_d = stf_q;
    if (bit_stb) begin
      if (stuff_due) begin
        bus_d = ~run_lvl;
        stf_d = 1'b1;
      end else if (tx_valid) begin
        bus_d = tx_data;
        stf_d = 1'b0;
      end else begin
        bus_d = can_stuff_pkg::LVL_REC;
        stf_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_q <= can_stuff_pkg::LVL_REC;
      stf_q <= 1'b0;
    end else begin
      bus_q <= bus_d;
      stf_q <= stf_d;
    end
  end

  assign tx_ready    = !stuff_due;
  assign tx_bit      = bus_q;
  assign tx_is_stuff = stf_q;

  // R1: a stuff bit flips the bus level and is flagged
  p_stuff_flip_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && !tx_ready) |=> (tx_is_stuff && (tx_bit != $past(tx_bit))));
  // R2: the stall lasts a single strobe
  p_ready_recover_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && !tx_ready) |=> tx_ready);
  // R7: nothing is stuffed while stuffing is off
  p_off_no_stuff_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && !stuff_en) |=> !tx_is_stuff);
  // R8: the bus level holds between strobes
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |=> $stable(tx_bit));
endmodule

// File: rtl/stuff_rx.sv
module stuff_rx #(
  parameter int unsigned RUN_LEN = can_stuff_pkg::DEF_RUN_LEN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic stuff_en,
  input  logic rx_bit,
  input  logic rx_sof,
  output logic rx_data_valid,
  output logic rx_data,
  output logic rx_stuff_err
);
  logic run_full, run_lvl;
  logic halt_q, halt_d;
  logic live, at_limit, is_stuff, is_err;
  logic trk_step, trk_clear;

  assign live      = bit_stb && (!halt_q || rx_sof);
  assign at_limit  = stuff_en && !rx_sof && run_full;
  assign is_stuff  = live && at_limit && (rx_bit != run_lvl);
  assign is_err    = live && at_limit && (rx_bit == run_lvl);
  assign trk_step  = live && stuff_en && !is_err;
  assign trk_clear = live && (!stuff_en || is_err);

  stuff_run_tracker #(.RUN_LEN(RUN_LEN)) u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (trk_step),
    .restart (rx_sof),
    .clear   (trk_clear),
    .bit_in  (rx_bit),
    .full    (run_full),
    .lvl     (run_lvl)
  );

  always_comb begin
    halt_d = halt_q;
    if (bit_stb && rx_sof) begin
      halt_d = 1'b0;
    end else if (is_err) begin
      halt_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
    end else begin
      halt_q <= halt_d;
    end
  end

  assign rx_data_valid = live && !is_stuff && !is_err;
  assign rx_data       = rx_bit;
  assign rx_stuff_err  = is_err;

  // R5: error is strobe-aligned and never delivers the bit
  p_err_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stuff_err |-> (bit_stb && !rx_data_valid));
  // R6: reception stays stopped after an error until a new frame
  p_halt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stuff_err |=> (!rx_data_valid || rx_sof));
  // R7: no error while stuffing is off
  p_off_no_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !stuff_en |-> !rx_stuff_err);
  // R8: receive strobes are silent between sample points
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_stb |-> (!rx_data_valid && !rx_stuff_err));
endmodule

// File: rtl/can_stuff_codec.sv
module can_stuff_codec #(
  parameter int unsigned RUN_LEN = can_stuff_pkg::DEF_RUN_LEN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic stuff_en,
  input  logic tx_valid,
  input  logic tx_data,
  input  logic tx_sof,
  output logic tx_ready,
  output logic tx_bit,
  output logic tx_is_stuff,
  input  logic rx_bit,
  input  logic rx_sof,
  output logic rx_data_valid,
  output logic rx_data,
  output logic rx_stuff_err
);
  stuff_tx #(.RUN_LEN(RUN_LEN)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_stb     (bit_stb),
    .stuff_en    (stuff_en),
    .tx_valid    (tx_valid),
    .tx_data     (tx_data),
    .tx_sof      (tx_sof),
    .tx_ready    (tx_ready),
    .tx_bit      (tx_bit),
    .tx_is_stuff (tx_is_stuff)
  );

  stuff_rx #(.RUN_LEN(RUN_LEN)) u_rx (
    .clk           (clk),
    .rst_n         (rst_n),
    .bit_stb       (bit_stb),
    .stuff_en      (stuff_en),
    .rx_bit        (rx_bit),
    .rx_sof        (rx_sof),
    .rx_data_valid (rx_data_valid),
    .rx_data       (rx_data),
    .rx_stuff_err  (rx_stuff_err)
  );
endmodule

// File: tb/can_stuff_codec_test.sv
`timescale 1ns/1ps
module can_stuff_codec_test;
  localparam int CLK_PERIOD = 10;
  localparam int RUN = 5;
  localparam int NB  = 10;

  logic clk = 1'b0;
  logic rst_n, bit_stb, stuff_en, tx_valid, tx_data, tx_sof, rx_bit, rx_sof;
  logic tx_ready, tx_bit, tx_is_stuff, rx_data_valid, rx_data, rx_stuff_err;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_stuff_codec #(.RUN_LEN(RUN)) uut (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .stuff_en(stuff_en),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_sof(tx_sof),
    .tx_ready(tx_ready), .tx_bit(tx_bit), .tx_is_stuff(tx_is_stuff),
    .rx_bit(rx_bit), .rx_sof(rx_sof), .rx_data_valid(rx_data_valid),
    .rx_data(rx_data), .rx_stuff_err(rx_stuff_err)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
  endtask

  // one strobe: inputs set by caller at a falling edge; returns at a falling edge
  task automatic strobe(output logic rdy, output logic rv, output logic rd, output logic re);
    bit_stb = 1'b1;
    #1;
    rdy = tx_ready; rv = rx_data_valid; rd = rx_data; re = rx_stuff_err;
    @(posedge clk);
    @(negedge clk);
    bit_stb = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fails++;
    n_checks++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    logic rdy, rv, rd, re, hold;
    rst_n = 1'b0; bit_stb = 1'b0; stuff_en = 1'b1; tx_valid = 1'b0; tx_data = 1'b0;
    tx_sof = 1'b0; rx_bit = 1'b1; rx_sof = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state, R8 quiet receive outputs
    chk(tx_bit === 1'b1, "R9 reset tx_bit", tx_bit, 1);
    chk(tx_ready === 1'b1 && tx_is_stuff === 1'b0, "R9 reset ready/stuff", tx_ready, 1);
    chk(rx_data_valid === 1'b0 && rx_stuff_err === 1'b0, "R8 rx quiet", rx_data_valid, 0);

    // R8: no strobe, offered dominant bit does not reach the bus
    tx_valid = 1'b1; tx_data = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(tx_bit === 1'b1, "R8 hold without strobe", tx_bit, 1);
    tx_valid = 1'b0;

    // loopback sweep: R1 R2 R3 R4 R5
    for (int p = 0; p < (1 << NB); p++) begin
      logic pl [NB+1];
      logic ex [32];
      logic gt [32];
      logic rg [32];
      int elen, nst, cnt, glen, rlen, stalls, errs, idx;
      logic lvl, prev_sof, rx_on, launched, ok;
      pl[0] = 1'b0;
      for (int i = 1; i <= NB; i++) pl[i] = p[i-1];
      elen = 0; nst = 0; cnt = 0; lvl = 1'b1;
      for (int i = 0; i <= NB; i++) begin
        ex[elen] = pl[i]; elen++;
        if (i == 0 || pl[i] != lvl) cnt = 1; else cnt++;
        lvl = pl[i];
        if (cnt == RUN) begin
          ex[elen] = ~lvl; elen++; lvl = ~lvl; cnt = 1; nst++;
        end
      end
      glen = 0; rlen = 0; stalls = 0; errs = 0; idx = 0;
      prev_sof = 1'b0; rx_on = 1'b0;
      stuff_en = 1'b1;
      for (int s = 0; s <= elen; s++) begin
        logic sof_now;
        tx_valid = (idx <= NB);
        tx_data  = (idx <= NB) ? pl[idx] : 1'b1;
        tx_sof   = (idx == 0);
        rx_bit   = tx_bit;
        rx_sof   = prev_sof;
        sof_now  = tx_valid && tx_ready && (idx == 0);
        launched = tx_valid || !tx_ready;
        strobe(rdy, rv, rd, re);
        prev_sof = sof_now;
        if (rx_sof) rx_on = 1'b1;
        if (rx_on) begin
          if (rv && rlen < 32) begin rg[rlen] = rd; rlen++; end
          if (re) errs++;
        end
        if (!rdy) stalls++;
        if (launched && glen < 32) begin gt[glen] = tx_bit; glen++; end
        if (tx_valid && rdy) idx++;
      end
      tx_valid = 1'b0; tx_sof = 1'b0; rx_sof = 1'b0;
      ok = (glen == elen);
      for (int i = 0; i < elen && i < glen; i++) if (gt[i] != ex[i]) ok = 1'b0;
      chk(ok, "R1 R3 stuffed tx stream", glen, elen);
      chk(stalls == nst, "R2 stall strobes", stalls, nst);
      ok = (rlen == NB + 1);
      for (int i = 0; i <= NB && i < rlen; i++) if (rg[i] != pl[i]) ok = 1'b0;
      chk(ok, "R4 recovered payload", rlen, NB + 1);
      chk(errs == 0, "R5 no error on legal stream", errs, 0);
    end

    // R9: idle strobe drives recessive
    tx_valid = 1'b0; rx_bit = 1'b1;
    strobe(rdy, rv, rd, re);
    chk(tx_bit === 1'b1 && tx_is_stuff === 1'b0, "R9 idle recessive", tx_bit, 1);

    // R4 explicit discard: 1 1111 then 0 stuff, then 0 data
    stuff_en = 1'b1; rx_sof = 1'b1; rx_bit = 1'b1;
    strobe(rdy, rv, rd, re);
    rx_sof = 1'b0;
    for (int i = 0; i < 4; i++) strobe(rdy, rv, rd, re);
    rx_bit = 1'b0;
    strobe(rdy, rv, rd, re);
    chk(rv === 1'b0 && re === 1'b0, "R4 stuff bit dropped", rv, 0);
    strobe(rdy, rv, rd, re);
    chk(rv === 1'b1 && rd === 1'b0, "R4 next bit delivered", rv, 1);

    // R5/R6: six dominant bits
    rx_sof = 1'b1; rx_bit = 1'b0;
    strobe(rdy, rv, rd, re);
    chk(rv === 1'b1, "R3 sof delivered", rv, 1);
    rx_sof = 1'b0;
    for (int i = 0; i < 4; i++) strobe(rdy, rv, rd, re);
    chk(rv === 1'b1 && re === 1'b0, "R5 fifth bit legal", rv, 1);
    strobe(rdy, rv, rd, re);
    chk(re === 1'b1, "R5 error on sixth", re, 1);
    chk(rv === 1'b0, "R5 sixth not delivered", rv, 0);
    chk(rx_stuff_err === 1'b0 && rx_data_valid === 1'b0, "R8 error pulse ends", rx_stuff_err, 0);
    rx_bit = 1'b1;
    strobe(rdy, rv, rd, re);
    chk(rv === 1'b0 && re === 1'b0, "R6 halted after error", rv, 0);
    rx_sof = 1'b1;
    strobe(rdy, rv, rd, re);
    chk(rv === 1'b1 && rd === 1'b1, "R6 resume at sof", rv, 1);
    rx_sof = 1'b0;

    // R7: stuffing off, seven recessive bits both ways
    stuff_en = 1'b0; tx_valid = 1'b1; tx_data = 1'b1; rx_bit = 1'b1;
    hold = 1'b1;
    for (int i = 0; i < 7; i++) begin
      strobe(rdy, rv, rd, re);
      if (!(rdy && rv && !re && tx_bit && !tx_is_stuff)) hold = 1'b0;
    end
    chk(hold, "R7 no stuffing when disabled", hold, 1);
    tx_valid = 1'b0; stuff_en = 1'b1;
    strobe(rdy, rv, rd, re);
    chk(tx_bit === 1'b1 && tx_is_stuff === 1'b0, "R7 no late stuff", tx_is_stuff, 0);

    summary();
    $finish;
  end
endmodule